// File: doc/BRIEF.md
# Grouped Multi-Channel Timer with Match-Driven PWM

This block holds a parameterized number of identical timer channels. Each channel has an up-counter and two general registers. Either general register can act as a compare value or, on its own setting, latch the counter when its capture input rises. The counter advances on every clock, or only on synchronized rising edges of a shared event input. It can also wrap back to zero after it reaches the value of either general register, so it acts as a free-running, periodic or event-counting timer.

Channels can join one synchronous group. When software writes the counter of any group member, every member takes the same value on the same edge. A member whose clear source is set to the group clears on the same edge as any member that clears on its own match. In PWM mode a channel's output pin rises after a match on register A and falls after a match on register B. When both match together, the pin goes low, so settings exist for both 0% and 100% duty. Software reaches the block through a single-cycle write port and a combinational read port, addressed by channel and register code.

Top module: `mtimer_group`

## Requirements
- R1: After reset every counter reads 0, every control register reads 0, both general registers of every channel read all ones, and every PWM output is low.
- R2: Register codes on wr_reg/rd_reg are 0 control, 1 counter, 2 general register A, 3 general register B. A counter write takes effect on the next clock edge and takes priority over counting and clearing. Writes and reads to a channel index at or above the channel count have no effect and read 0.
- R3: Control bit layout: [1:0] clear select (00 none, 01 on match A, 10 on match B, 11 group clear), [2] event clock, [3] A is capture, [4] B is capture, [5] PWM mode, [6] group member. With event clock 0 and clear select 00, the counter increments once per clock and wraps from all ones to 0.
- R4: With clear select 01 (or 10), the counter runs 0 up to the value of register A (or B) and returns to 0 on the following edge, a period of that value plus one clocks.
- R5: With event clock set to 1, the counter increments exactly once per rising edge of ev_in (after a two-flop synchronizer) and holds its value otherwise.
- R6: When a general register's capture bit is set and PWM mode is off, a rising edge on that register's capture input (after a two-flop synchronizer) copies the counter value into the register. A software write to the same register in the same cycle wins.
- R7: When a general register's capture bit is clear, its capture input has no effect on the register.
- R8: A counter write addressed to any group member loads the written value into every group member on the same edge. Non-members are unchanged.
- R9: A group member with clear select 11 returns to 0 on the same edge as any group member that clears on its own match, even when it is not ticking. A non-member with clear select 11 never clears.
- R10: In PWM mode the output goes high on the edge after the counter equals register A and low on the edge after it equals register B. Low wins when both match together. With clear on B and A < B, the output is high for B−A of every B+1 clocks. A = B gives 0%. Clear on A with B above A gives 100%.
- R11: PWM mode treats both general registers as compare registers whatever their capture bits, and capture inputs then leave them unchanged.
- R12: With PWM mode off, the channel's PWM output stays low even while compare matches occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_ch | input | CHW | Channel index of the write |
| wr_reg | input | 2 | Register code of the write |
| wr_data | input | CW | Write data |
| rd_ch | input | CHW | Channel index of the read |
| rd_reg | input | 2 | Register code of the read |
| rd_data | output | CW | Combinational read data |
| cap_a_in | input | NCH | Per-channel capture input for register A |
| cap_b_in | input | NCH | Per-channel capture input for register B |
| ev_in | input | 1 | Shared external event clock input |
| pwm_out | output | NCH | Per-channel PWM output |

## Verification
A wrong counter state shows on the read port within one clock. It then stays visible as a wrong period, because the counter value decides every later match and wrap. A fault in group wiring shows as members that disagree after a single counter write or a single clear. A fault in the set/reset priority of the PWM flop shows as a high-time count that is off by whole periods over a window of two periods. This includes a 0% setting that leaks pulses.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

   typedef enum logic [1:0] {
      CLR_NONE  = 2'b00,
      CLR_ON_A  = 2'b01,
      CLR_ON_B  = 2'b10,
      CLR_GROUP = 2'b11
   } clr_sel_e;

   typedef struct packed {
      logic     grp_mbr;
      logic     pwm_en;
      logic     b_capt;
      logic     a_capt;
      logic     ev_clk;
      clr_sel_e clr_sel;
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_CNT  = 2'd1;
   localparam logic [1:0] REG_GRA  = 2'd2;
   localparam logic [1:0] REG_GRB  = 2'd3;

endpackage

// File: rtl/mtimer_edge.sv
module mtimer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mtimer_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-1:0], din};
   end

   assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
   import mtimer_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic          gra_we,
   input  logic          grb_we,
   input  logic          cnt_load,
   input  logic [CW-1:0] wdata,
   input  logic          ev_tick,
   input  logic          cap_a_ev,
   input  logic          cap_b_ev,
   input  logic          grp_clr,
   output tmr_ctrl_t     ctrl,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] gra,
   output logic [CW-1:0] grb,
   output logic          clr_req,
   output logic          pwm
);
   if (CW < CTRL_W) begin : g_bad_cw
      $error("mtimer_channel: CW narrower than control register");
   end

   tmr_ctrl_t     ctrl_q;
   logic [CW-1:0] cnt_q, gra_q, grb_q;
   logic          pwm_q;
   logic          tick, a_cmp, b_cmp, hit_a, hit_b, clr_now;

   assign tick   = ctrl_q.ev_clk ? ev_tick : 1'b1;
   assign a_cmp  = ctrl_q.pwm_en | ~ctrl_q.a_capt;
   assign b_cmp  = ctrl_q.pwm_en | ~ctrl_q.b_capt;
   assign hit_a  = tick & a_cmp & (cnt_q == gra_q);
   assign hit_b  = tick & b_cmp & (cnt_q == grb_q);

   assign clr_req = ((ctrl_q.clr_sel == CLR_ON_A) & hit_a) |
                    ((ctrl_q.clr_sel == CLR_ON_B) & hit_b);
   assign clr_now = clr_req | ((ctrl_q.clr_sel == CLR_GROUP) & grp_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (cnt_load) cnt_q <= wdata;
      else if (clr_now)  cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     gra_q <= '1;
      else if (gra_we)                gra_q <= wdata;
      else if (!a_cmp && cap_a_ev)    gra_q <= cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     grb_q <= '1;
      else if (grb_we)                grb_q <= wdata;
      else if (!b_cmp && cap_b_ev)    grb_q <= cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pwm_q <= 1'b0;
      else if (!ctrl_q.pwm_en) pwm_q <= 1'b0;
      else if (hit_b)          pwm_q <= 1'b0;
      else if (hit_a)          pwm_q <= 1'b1;
   end

   assign ctrl = ctrl_q;
   assign cnt  = cnt_q;
   assign gra  = gra_q;
   assign grb  = grb_q;
   assign pwm  = pwm_q;

   // R4
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !cnt_load) |=> (cnt_q == '0));

   // R5
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.ev_clk && !ev_tick && !cnt_load && !clr_now) |=> $stable(cnt_q));

   // R6
   cap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_cmp && cap_a_ev && !gra_we) |=> (gra_q == $past(cnt_q)));

   // R10
   pwm_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.pwm_en && hit_b) |=> !pwm_q);

   // R12
   pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.pwm_en |=> !pwm_q);
endmodule

// File: rtl/mtimer_group.sv
module mtimer_group
   import mtimer_pkg::*;
#(
   parameter int NCH         = 3,
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [CHW-1:0] wr_ch,
   input  logic [1:0]     wr_reg,
   input  logic [CW-1:0]  wr_data,
   input  logic [CHW-1:0] rd_ch,
   input  logic [1:0]     rd_reg,
   output logic [CW-1:0]  rd_data,
   input  logic [NCH-1:0] cap_a_in,
   input  logic [NCH-1:0] cap_b_in,
   input  logic           ev_in,
   output logic [NCH-1:0] pwm_out
);
   if (NCH < 2) begin : g_bad_nch
      $error("mtimer_group: NCH must be at least 2");
   end
   if (CW < CTRL_W) begin : g_bad_cw
      $error("mtimer_group: CW narrower than control register");
   end

   tmr_ctrl_t     ctrl_v [NCH];
   logic [CW-1:0] cnt_v  [NCH];
   logic [CW-1:0] gra_v  [NCH];
   logic [CW-1:0] grb_v  [NCH];
   logic [NCH-1:0] member, clr_req_v;
   logic          ev_tick, wr_grp, grp_clr;

   mtimer_edge #(.STAGES(SYNC_STAGES)) u_ev_edge (
      .clk(clk), .rst_n(rst_n), .din(ev_in), .rise(ev_tick));

   always_comb begin
      wr_grp = 1'b0;
      for (int j = 0; j < NCH; j++) begin
         if (wr_ch == CHW'(j) && member[j]) wr_grp = 1'b1;
      end
   end

   assign grp_clr = |(clr_req_v & member);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_me, cap_a_ev, cap_b_ev;
      assign sel_me = wr_en && (wr_ch == CHW'(i));

      mtimer_edge #(.STAGES(SYNC_STAGES)) u_cap_a (
         .clk(clk), .rst_n(rst_n), .din(cap_a_in[i]), .rise(cap_a_ev));
      mtimer_edge #(.STAGES(SYNC_STAGES)) u_cap_b (
         .clk(clk), .rst_n(rst_n), .din(cap_b_in[i]), .rise(cap_b_ev));

      mtimer_channel #(.CW(CW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctrl_we  (sel_me && wr_reg == REG_CTRL),
         .gra_we   (sel_me && wr_reg == REG_GRA),
         .grb_we   (sel_me && wr_reg == REG_GRB),
         .cnt_load (wr_en && wr_reg == REG_CNT &&
                    ((wr_ch == CHW'(i)) || (wr_grp && member[i]))),
         .wdata    (wr_data),
         .ev_tick  (ev_tick),
         .cap_a_ev (cap_a_ev),
         .cap_b_ev (cap_b_ev),
         .grp_clr  (grp_clr && member[i]),
         .ctrl     (ctrl_v[i]),
         .cnt      (cnt_v[i]),
         .gra      (gra_v[i]),
         .grb      (grb_v[i]),
         .clr_req  (clr_req_v[i]),
         .pwm      (pwm_out[i])
      );

      assign member[i] = ctrl_v[i].grp_mbr;

      // R8
      sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_reg == REG_CNT && wr_grp && member[i])
            |=> (cnt_v[i] == $past(wr_data)));

      // R9
      sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_clr && member[i] && ctrl_v[i].clr_sel == CLR_GROUP &&
          !(wr_en && wr_reg == REG_CNT)) |=> (cnt_v[i] == '0));
   end

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < NCH; j++) begin
         if (rd_ch == CHW'(j)) begin
            case (rd_reg)
               REG_CTRL: rd_data = CW'(ctrl_v[j]);
               REG_CNT:  rd_data = cnt_v[j];
               REG_GRA:  rd_data = gra_v[j];
               default:  rd_data = grb_v[j];
            endcase
         end
      end
   end
endmodule

// File: tb/mtimer_group_tb.sv
`timescale 1ns/1ps
module mtimer_group_tb;
   localparam int NCH = 3;
   localparam int CW  = 16;
   localparam int CHW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [CHW-1:0] wr_ch = '0;
   logic [1:0]     wr_reg = '0;
   logic [CW-1:0]  wr_data = '0;
   logic [CHW-1:0] rd_ch = '0;
   logic [1:0]     rd_reg = '0;
   logic [CW-1:0]  rd_data;
   logic [NCH-1:0] cap_a_in = '0;
   logic [NCH-1:0] cap_b_in = '0;
   logic           ev_in = 1'b0;
   logic [NCH-1:0] pwm_out;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   mtimer_group #(.NCH(NCH), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg),
      .wr_data(wr_data), .rd_ch(rd_ch), .rd_reg(rd_reg), .rd_data(rd_data),
      .cap_a_in(cap_a_in), .cap_b_in(cap_b_in), .ev_in(ev_in), .pwm_out(pwm_out));

   function automatic logic [15:0] mk_ctrl(input bit grp, input bit pwm,
      input bit bcap, input bit acap, input bit ev, input logic [1:0] sel);
      return {9'd0, grp, pwm, bcap, acap, ev, sel};
   endfunction

   function automatic int exp_high(input int a, input int b, input int periods);
      if (a >= b) return 0;
      return (b - a) * periods;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int ch, input logic [1:0] r, input logic [15:0] d);
      wr_en = 1'b1; wr_ch = CHW'(ch); wr_reg = r; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int ch, input logic [1:0] r, output logic [15:0] d);
      rd_ch = CHW'(ch); rd_reg = r;
      #0.5;
      d = rd_data;
   endtask

   task automatic pulse_cap(input bit on_b, input int ch);
      if (on_b) cap_b_in[ch] = 1'b1; else cap_a_in[ch] = 1'b1;
      idle(4);
      cap_a_in = '0; cap_b_in = '0;
      idle(4);
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_out[0]) hi++;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v, v1, v2, x;
      int k, a, b, p, n, hi;
      void'($urandom(32'd20240611));

      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state (counters held at 0 needs ctrl=0 so count runs; read right away)
      rd(0, 2'd0, v);  check("R1 ctrl", v, 16'h0);
      rd(1, 2'd2, v);  check("R1 gra", v, 16'hFFFF);
      rd(2, 2'd3, v);  check("R1 grb", v, 16'hFFFF);
      check("R1 pwm", pwm_out, 3'b000);
      rd(3, 2'd1, v);  check("R2 out-of-range read", v, 16'h0);

      // R3 free running, directed wrap then random
      wr(0, 2'd1, 16'hFFFF);
      idle(1);
      rd(0, 2'd1, v); check("R3 wrap", v, 16'h0000);
      for (int t = 0; t < 4; t++) begin
         x = 16'($urandom);
         k = 1 + int'($urandom % 20);
         wr(0, 2'd1, x);
         idle(k);
         rd(0, 2'd1, v); check("R3 free count", v, 16'(x + 16'(k)));
      end

      // R2 write to out-of-range channel leaves channels alone
      wr(1, 2'd0, mk_ctrl(0,0,0,0,1,2'b00));
      wr(1, 2'd1, 16'h0042);
      wr(3, 2'd1, 16'h1111);
      rd(1, 2'd1, v); check("R2 no alias", v, 16'h0042);

      // R4 periodic on A and on B
      for (int t = 0; t < 3; t++) begin
         p = 2 + int'($urandom % 25);
         wr(0, 2'd0, mk_ctrl(0,0,0,0,0,2'b01));
         wr(0, 2'd2, 16'(p));
         wr(0, 2'd1, 16'h0);
         idle(p);
         rd(0, 2'd1, v); check("R4 reach A", v, 16'(p));
         idle(1);
         rd(0, 2'd1, v); check("R4 wrap A", v, 16'h0);
      end
      p = 9;
      wr(0, 2'd0, mk_ctrl(0,0,0,0,0,2'b10));
      wr(0, 2'd3, 16'(p));
      wr(0, 2'd1, 16'h0);
      idle(2 * (p + 1) + 3);
      rd(0, 2'd1, v); check("R4 period B", v, 16'd3);

      // R5 event counting
      wr(0, 2'd0, mk_ctrl(0,0,0,0,1,2'b00));
      wr(0, 2'd1, 16'd5);
      idle(6);
      rd(0, 2'd1, v); check("R5 hold without events", v, 16'd5);
      n = 1 + int'($urandom % 10);
      for (int e = 0; e < n; e++) begin
         ev_in = 1'b1; idle(3);
         ev_in = 1'b0; idle(3);
      end
      idle(4);
      rd(0, 2'd1, v); check("R5 event count", v, 16'(5 + n));

      // R6 capture A and B on a frozen counter
      wr(0, 2'd0, mk_ctrl(0,0,1,1,1,2'b00));
      x = 16'($urandom);
      wr(0, 2'd1, x);
      pulse_cap(0, 0);
      rd(0, 2'd2, v); check("R6 capture A", v, x);
      pulse_cap(1, 0);
      rd(0, 2'd3, v); check("R6 capture B", v, x);

      // R7 capture ignored in compare mode
      wr(0, 2'd0, mk_ctrl(0,0,0,0,1,2'b00));
      wr(0, 2'd2, 16'h1234);
      wr(0, 2'd1, 16'h0777);
      pulse_cap(0, 0);
      rd(0, 2'd2, v); check("R7 A unchanged", v, 16'h1234);

      // R8 group load
      wr(0, 2'd0, mk_ctrl(1,0,0,0,1,2'b00));
      wr(1, 2'd0, mk_ctrl(1,0,0,0,1,2'b00));
      wr(2, 2'd0, mk_ctrl(0,0,0,0,1,2'b00));
      wr(2, 2'd1, 16'h0BEE);
      x = 16'($urandom);
      wr(1, 2'd1, x);
      rd(0, 2'd1, v);  check("R8 member 0 loaded", v, x);
      rd(1, 2'd1, v1); check("R8 member 1 loaded", v1, x);
      rd(2, 2'd1, v2); check("R8 non-member kept", v2, 16'h0BEE);

      // R9 group clear
      p = 6 + int'($urandom % 10);
      wr(2, 2'd0, mk_ctrl(0,0,0,0,1,2'b11));
      wr(2, 2'd1, 16'h0055);
      wr(0, 2'd2, 16'(p));
      wr(0, 2'd0, mk_ctrl(1,0,0,0,0,2'b01));
      wr(1, 2'd0, mk_ctrl(1,0,0,0,0,2'b11));
      wr(0, 2'd1, 16'h0);
      idle(p);
      rd(1, 2'd1, v); check("R9 member before clear", v, 16'(p));
      idle(1);
      rd(0, 2'd1, v);  check("R9 source cleared", v, 16'h0);
      rd(1, 2'd1, v1); check("R9 member cleared", v1, 16'h0);
      rd(2, 2'd1, v2); check("R9 non-member kept", v2, 16'h0055);
      wr(1, 2'd0, mk_ctrl(0,0,0,0,0,2'b00));
      wr(2, 2'd0, mk_ctrl(0,0,0,0,0,2'b00));

      // R12 no PWM output outside PWM mode
      wr(0, 2'd0, mk_ctrl(0,0,0,0,0,2'b01));
      wr(0, 2'd2, 16'd3);
      wr(0, 2'd3, 16'd1);
      count_high(20, hi);
      check("R12 output low", 32'(hi), 32'd0);

      // R10/R11 PWM random set/clear with capture bits set
      for (int t = 0; t < 4; t++) begin
         b = 2 + int'($urandom % 30);
         a = int'($urandom % b);
         wr(0, 2'd0, mk_ctrl(0,1,1,1,0,2'b10));
         wr(0, 2'd2, 16'(a));
         wr(0, 2'd3, 16'(b));
         wr(0, 2'd1, 16'h0);
         pulse_cap(0, 0);
         idle(b + 2);
         count_high(2 * (b + 1), hi);
         check("R10 pwm high time", 32'(hi), 32'(exp_high(a, b, 2)));
         rd(0, 2'd2, v); check("R11 A stays compare", v, 16'(a));
      end

      // R10 0% duty: A equals B
      b = 3 + int'($urandom % 20);
      wr(0, 2'd0, mk_ctrl(0,1,0,0,0,2'b10));
      wr(0, 2'd2, 16'(b));
      wr(0, 2'd3, 16'(b));
      wr(0, 2'd1, 16'h0);
      idle(b + 2);
      count_high(2 * (b + 1), hi);
      check("R10 zero duty", 32'(hi), 32'd0);

      // R10 100% duty: clear on A, B out of reach
      a = 3 + int'($urandom % 20);
      wr(0, 2'd0, mk_ctrl(0,1,0,0,0,2'b01));
      wr(0, 2'd2, 16'(a));
      wr(0, 2'd3, 16'hFFFF);
      wr(0, 2'd1, 16'h0);
      idle(a + 2);
      count_high(2 * (a + 1), hi);
      check("R10 full duty", 32'(hi), 32'(2 * (a + 1)));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule